// File: doc/BRIEF.md
# PLL Control and Status Register Block

This block gives software a two-register window onto a clock generator's phase-locked loop. The control register holds the loop enable, the bandwidth and acquisition selects, the pseudo-stop select, the two interrupt enables and a bit that blocks limp-home operation. The status register reports whether the loop is locked and whether the generator has fallen back to limp-home running after losing its reference. It also holds two sticky change flags that software clears by writing ones.

The analog loop, its oscillator and the reference-loss detector sit outside the block and appear only as input signals. The raw lock and reference-lost inputs are resynchronised into the register clock domain before any status logic sees them. The supply-good input is taken as already synchronous. While the loop's supply is low, the block pins three control bits to safe values. The interrupt request combines each change flag with its enable.

Top module: `pll_regblock`

## Requirements
- R1: Address CTRL_ADDR (default 0) selects the control register and STAT_ADDR (default 1) the status register. Reads are combinational. Control bit positions are: 7 lock interrupt enable, 6 loop enable, 5 automatic bandwidth, 4 acquisition, 3 always reads 0, 2 pseudo-stop, 1 limp-home interrupt enable, 0 limp-home disable.
- R2: During reset the status register clears to 0. The control register loads 0x60 when supply_ok is 1, and 0x21 when it is 0.
- R3: Status bit 2 (lock) is 1 only when the loop enable is set, the synchronised lock input is 1 and limp-home is not active. Writes to bit 2 have no effect.
- R4: Status bit 0 (limp-home) follows the reference-lost input through SYNC_STAGES flops. With the default of 2 it changes on the third rising edge after the input changes. It reads 0 while the reference is present.
- R5: Status bit 1 (limp-home change flag) sets on every change of status bit 0, both entry and exit. Writing 1 to it clears it.
- R6: Status bit 3 (lock change flag) sets on every change of status bit 2. Writing 1 to it clears it. Status bits 7:4 read 0.
- R7: When a flag sets in the same cycle that a write-1-to-clear hits it, the flag ends up set.
- R8: While supply_ok is 0, the loop enable and the lock interrupt enable are held at 0 and limp-home disable is held at 1, and writes to those three bits are ignored. The other control bits stay writable.
- R9: While limp-home disable is 1, loss of the reference does not enter limp-home, and status bit 0 stays 0.
- R10: irq is (lock interrupt enable AND lock change flag) OR (limp-home interrupt enable AND limp-home change flag). It is combinational when IRQ_REG is 0.
- R11: Outputs pll_en, bw_auto, acq_sel and pseudo_stop carry the matching control bits, and lh_active carries status bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | ADDR_W | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data of the selected register |
| lock_raw | input | 1 | Asynchronous lock-detector output |
| ref_lost | input | 1 | Asynchronous reference-loss indication |
| supply_ok | input | 1 | Loop supply present, synchronous |
| pll_en | output | 1 | Loop enable to the PLL |
| bw_auto | output | 1 | Automatic bandwidth select |
| acq_sel | output | 1 | Acquisition select |
| pseudo_stop | output | 1 | Pseudo-stop select |
| lh_active | output | 1 | Limp-home clock selected |
| irq | output | 1 | Interrupt request |

## Verification
The limp-home path is driven through entry, exit, entry with limp-home disabled, and entry coinciding with a clear write. These separate a flag that only catches rising edges from one that catches both, and a clear that wins from a set that wins. The lock input is toggled with the loop enabled and disabled, and inside and outside limp-home, which tells the three conditions of the lock bit apart. Control writes of all ones are repeated with the supply high and low, and resets are taken at both supply levels, which shows which bits are forced and which stay free.

// File: rtl/pllreg_pkg.sv
package pllreg_pkg;

   localparam int CB_LOCK_IE = 7;
   localparam int CB_PLL_ON  = 6;
   localparam int CB_AUTO_BW = 5;
   localparam int CB_ACQ     = 4;
   localparam int CB_PSTP    = 2;
   localparam int CB_LH_IE   = 1;
   localparam int CB_NO_LH   = 0;

   localparam int SB_LH       = 0;
   localparam int SB_LH_FLAG  = 1;
   localparam int SB_LOCK     = 2;
   localparam int SB_LK_FLAG  = 3;

   typedef struct packed {
      logic lock_ie;
      logic pll_on;
      logic auto_bw;
      logic acq;
      logic pstp;
      logic lh_ie;
      logic no_lh;
   } pll_ctrl_t;

   typedef struct packed {
      logic lock_flag;
      logic lock;
      logic lh_flag;
      logic lh;
   } pll_stat_t;

   function automatic pll_ctrl_t ctrl_reset(input logic sup);
      pll_ctrl_t c;
      c.lock_ie = 1'b0;
      c.pll_on  = sup;
      c.auto_bw = 1'b1;
      c.acq     = 1'b0;
      c.pstp    = 1'b0;
      c.lh_ie   = 1'b0;
      c.no_lh   = ~sup;
      return c;
   endfunction

   function automatic logic [7:0] ctrl_to_byte(input pll_ctrl_t c);
      logic [7:0] b;
      b = 8'h00;
      b[CB_LOCK_IE] = c.lock_ie;
      b[CB_PLL_ON]  = c.pll_on;
      b[CB_AUTO_BW] = c.auto_bw;
      b[CB_ACQ]     = c.acq;
      b[CB_PSTP]    = c.pstp;
      b[CB_LH_IE]   = c.lh_ie;
      b[CB_NO_LH]   = c.no_lh;
      return b;
   endfunction

   function automatic logic [7:0] stat_to_byte(input pll_stat_t s);
      logic [7:0] b;
      b = 8'h00;
      b[SB_LH]      = s.lh;
      b[SB_LH_FLAG] = s.lh_flag;
      b[SB_LOCK]    = s.lock;
      b[SB_LK_FLAG] = s.lock_flag;
      return b;
   endfunction

endpackage

// File: rtl/pllreg_sync.sv
module pllreg_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);

   if (STAGES < 2) begin : g_bad_stages
      $error("pllreg_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= d_async;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/pllreg_ctrl.sv
module pllreg_ctrl
   import pllreg_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       supply_ok,
   input  logic       wr_en,
   input  logic [7:0] wdata,
   output pll_ctrl_t  ctrl
);

   pll_ctrl_t ctrl_d;

   always_comb begin
      ctrl_d = ctrl;
      if (wr_en) begin
         ctrl_d.lock_ie = wdata[CB_LOCK_IE];
         ctrl_d.pll_on  = wdata[CB_PLL_ON];
         ctrl_d.auto_bw = wdata[CB_AUTO_BW];
         ctrl_d.acq     = wdata[CB_ACQ];
         ctrl_d.pstp    = wdata[CB_PSTP];
         ctrl_d.lh_ie   = wdata[CB_LH_IE];
         ctrl_d.no_lh   = wdata[CB_NO_LH];
      end
      if (!supply_ok) begin
         ctrl_d.lock_ie = 1'b0;
         ctrl_d.pll_on  = 1'b0;
         ctrl_d.no_lh   = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) ctrl <= ctrl_reset(supply_ok);
      else        ctrl <= ctrl_d;
   end

   // R8: a low supply pins the three guarded bits on the next edge
   a_r8_supply_forced: assert property (@(posedge clk) disable iff (!rst_n)
      !supply_ok |=> (!ctrl.pll_on && !ctrl.lock_ie && ctrl.no_lh));

endmodule

// File: rtl/pllreg_status.sv
module pllreg_status
   import pllreg_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      ref_lost_s,
   input  logic      lock_s,
   input  logic      pll_on,
   input  logic      no_lh,
   input  logic      clr_lh,
   input  logic      clr_lock,
   output pll_stat_t stat
);

   logic lh_d, lock_d, lh_evt, lock_evt;
   pll_stat_t stat_d;

   always_comb begin
      lh_d     = ref_lost_s & ~no_lh;
      lock_d   = pll_on & lock_s & ~lh_d;
      lh_evt   = lh_d ^ stat.lh;
      lock_evt = lock_d ^ stat.lock;
      stat_d.lh        = lh_d;
      stat_d.lock      = lock_d;
      stat_d.lh_flag   = lh_evt   | (stat.lh_flag   & ~clr_lh);
      stat_d.lock_flag = lock_evt | (stat.lock_flag & ~clr_lock);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) stat <= '0;
      else        stat <= stat_d;
   end

   // R3: lock never reads 1 while limp-home is active
   a_r3_lock_clear_in_lh: assert property (@(posedge clk) disable iff (!rst_n)
      stat.lh |-> !stat.lock);

   // R5: any change of the limp-home bit leaves its flag set
   a_r5_lh_flag_on_change: assert property (@(posedge clk) disable iff (!rst_n)
      (stat.lh != $past(stat.lh)) |-> stat.lh_flag);

   // R5: the limp-home flag only falls through a clear write
   a_r5_lh_flag_fall: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(stat.lh_flag) && !stat.lh_flag) |-> $past(clr_lh));

   // R6: any change of the lock bit leaves its flag set
   a_r6_lock_flag_on_change: assert property (@(posedge clk) disable iff (!rst_n)
      (stat.lock != $past(stat.lock)) |-> stat.lock_flag);

   // R9: with limp-home disabled the status bit stays low
   a_r9_nolh_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      $past(no_lh) |-> !stat.lh);

endmodule

// File: rtl/pll_regblock.sv
module pll_regblock
   import pllreg_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 1,
   parameter int CTRL_ADDR   = 0,
   parameter int STAT_ADDR   = 1,
   parameter int SYNC_STAGES = 2,
   parameter bit IRQ_REG     = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              lock_raw,
   input  logic              ref_lost,
   input  logic              supply_ok,
   output logic              pll_en,
   output logic              bw_auto,
   output logic              acq_sel,
   output logic              pseudo_stop,
   output logic              lh_active,
   output logic              irq
);

   localparam logic [ADDR_W-1:0] CTRL_SEL = ADDR_W'(CTRL_ADDR);
   localparam logic [ADDR_W-1:0] STAT_SEL = ADDR_W'(STAT_ADDR);

   if (DATA_W != 8) begin : g_bad_width
      $error("pll_regblock: DATA_W must be 8");
   end
   if (CTRL_ADDR == STAT_ADDR) begin : g_bad_map
      $error("pll_regblock: register addresses must differ");
   end
   if (CTRL_ADDR >= (1 << ADDR_W) || STAT_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("pll_regblock: address does not fit ADDR_W");
   end

   pll_ctrl_t ctrl;
   pll_stat_t stat;
   logic      lock_s, ref_lost_s;
   logic      ctrl_we, stat_we, irq_c;
   logic [7:0] wbyte, rbyte;

   assign wbyte   = bus_wdata[7:0];
   assign ctrl_we = bus_wr && (bus_addr == CTRL_SEL);
   assign stat_we = bus_wr && (bus_addr == STAT_SEL);

   pllreg_sync #(.STAGES(SYNC_STAGES)) i_sync_lock (
      .clk(clk), .rst_n(rst_n), .d_async(lock_raw), .q_sync(lock_s));

   pllreg_sync #(.STAGES(SYNC_STAGES)) i_sync_ref (
      .clk(clk), .rst_n(rst_n), .d_async(ref_lost), .q_sync(ref_lost_s));

   pllreg_ctrl i_ctrl (
      .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok),
      .wr_en(ctrl_we), .wdata(wbyte), .ctrl(ctrl));

   pllreg_status i_status (
      .clk(clk), .rst_n(rst_n),
      .ref_lost_s(ref_lost_s), .lock_s(lock_s),
      .pll_on(ctrl.pll_on), .no_lh(ctrl.no_lh),
      .clr_lh(stat_we && wbyte[SB_LH_FLAG]),
      .clr_lock(stat_we && wbyte[SB_LK_FLAG]),
      .stat(stat));

   always_comb begin
      rbyte = 8'h00;
      if (bus_addr == CTRL_SEL)      rbyte = ctrl_to_byte(ctrl);
      else if (bus_addr == STAT_SEL) rbyte = stat_to_byte(stat);
   end
   assign bus_rdata = DATA_W'(rbyte);

   assign pll_en      = ctrl.pll_on;
   assign bw_auto     = ctrl.auto_bw;
   assign acq_sel     = ctrl.acq;
   assign pseudo_stop = ctrl.pstp;
   assign lh_active   = stat.lh;

   assign irq_c = (ctrl.lock_ie & stat.lock_flag) | (ctrl.lh_ie & stat.lh_flag);

   if (IRQ_REG) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= irq_c;
      end
      assign irq = irq_q;
   end else begin : g_irq_comb
      assign irq = irq_c;
   end

   // R10: no request without a pending, enabled flag (one cycle of slack for the registered variant)
   a_r10_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ((stat.lock_flag || $past(stat.lock_flag)) ||
               (stat.lh_flag   || $past(stat.lh_flag))));

endmodule

// File: tb/test_pll_regblock.sv
module test_pll_regblock;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [0:0] bus_addr = 1'b0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       lock_raw = 1'b0;
   logic       ref_lost = 1'b0;
   logic       supply_ok = 1'b0;
   logic       pll_en, bw_auto, acq_sel, pseudo_stop, lh_active, irq;

   int total = 0;
   int bad = 0;

   always #10 clk = ~clk;

   pll_regblock i_pll_regblock (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lock_raw(lock_raw),
      .ref_lost(ref_lost), .supply_ok(supply_ok), .pll_en(pll_en),
      .bw_auto(bw_auto), .acq_sel(acq_sel), .pseudo_stop(pseudo_stop),
      .lh_active(lh_active), .irq(irq));

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic a, output logic [7:0] d);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic do_reset(input logic sup);
      @(negedge clk);
      supply_ok = sup; rst_n = 1'b0;
      idle(3);
      rst_n = 1'b1;
   endtask

   task automatic t_reset;
      logic [7:0] v;
      do_reset(1'b0);
      rd(1'b0, v); chk("R2 ctrl reset supply low", v, 8'h21);
      do_reset(1'b1);
      rd(1'b0, v); chk("R2 ctrl reset supply high", v, 8'h60);
      rd(1'b1, v); chk("R2 status reset", v, 8'h00);
      chk("R11 pll_en/bw_auto after reset", {6'd0, pll_en, bw_auto}, 8'h03);
      chk("R10 irq idle", {7'd0, irq}, 8'h00);
   endtask

   task automatic t_ctrl_rw;
      logic [7:0] v;
      wr(1'b0, 8'hFF);
      rd(1'b0, v); chk("R1 ctrl all ones, bit3 zero", v, 8'hF7);
      chk("R11 control outputs", {4'd0, pll_en, bw_auto, acq_sel, pseudo_stop}, 8'h0F);
      wr(1'b0, 8'h76);
      rd(1'b0, v); chk("R1 ctrl pattern", v, 8'h76);
   endtask

   task automatic t_lock;
      logic [7:0] v;
      lock_raw = 1'b1; idle(4);
      rd(1'b1, v); chk("R3 R6 lock set with flag", v, 8'h0C);
      wr(1'b1, 8'h04);
      rd(1'b1, v); chk("R3 write to lock ignored", v, 8'h0C);
      wr(1'b1, 8'h08);
      rd(1'b1, v); chk("R6 lock flag cleared", v, 8'h04);
      wr(1'b0, 8'h36); idle(2);
      rd(1'b1, v); chk("R3 lock needs loop enable", v, 8'h08);
      wr(1'b1, 8'h08);
      wr(1'b0, 8'h76); idle(2);
      wr(1'b1, 8'h08);
      rd(1'b1, v); chk("R3 lock back", v, 8'h04);
   endtask

   task automatic t_limp;
      logic [7:0] v;
      @(negedge clk); ref_lost = 1'b1;
      idle(2);
      rd(1'b1, v); chk("R4 limp-home not yet after two edges", v & 8'h01, 8'h00);
      idle(1);
      rd(1'b1, v); chk("R4 R3 R5 limp-home entry", v, 8'h0B);
      chk("R11 lh_active", {7'd0, lh_active}, 8'h01);
      chk("R10 irq from limp-home flag", {7'd0, irq}, 8'h01);
      wr(1'b1, 8'h0A);
      rd(1'b1, v); chk("R5 flags cleared", v, 8'h01);
      chk("R10 irq drops", {7'd0, irq}, 8'h00);
      ref_lost = 1'b0; idle(4);
      rd(1'b1, v); chk("R5 exit sets flag", v, 8'h0E);
      wr(1'b1, 8'h0A);
      rd(1'b1, v); chk("R4 normal running", v, 8'h04);
   endtask

   task automatic t_lock_irq;
      logic [7:0] v;
      wr(1'b0, 8'hF4);
      lock_raw = 1'b0; idle(4);
      rd(1'b1, v); chk("R6 lock loss flag", v, 8'h08);
      chk("R10 irq from lock flag", {7'd0, irq}, 8'h01);
      wr(1'b0, 8'h74); idle(1);
      chk("R10 irq masked", {7'd0, irq}, 8'h00);
      wr(1'b1, 8'h08);
      wr(1'b0, 8'h76);
   endtask

   task automatic t_set_wins;
      logic [7:0] v;
      @(negedge clk); ref_lost = 1'b1;
      @(negedge clk);
      @(negedge clk);
      bus_addr = 1'b1; bus_wr = 1'b1; bus_wdata = 8'h0A;
      @(negedge clk); bus_wr = 1'b0;
      rd(1'b1, v); chk("R7 set beats clear", v, 8'h03);
   endtask

   task automatic t_nolh;
      logic [7:0] v;
      wr(1'b0, 8'h77); idle(1);
      wr(1'b1, 8'h0A);
      rd(1'b1, v); chk("R9 limp-home left when disabled", v, 8'h00);
      ref_lost = 1'b0; idle(4);
      ref_lost = 1'b1; idle(4);
      rd(1'b1, v); chk("R9 loss ignored", v, 8'h00);
      chk("R9 lh_active low", {7'd0, lh_active}, 8'h00);
      ref_lost = 1'b0; idle(4);
   endtask

   task automatic t_supply;
      logic [7:0] v;
      @(negedge clk); supply_ok = 1'b0;
      idle(1);
      chk("R8 pll_en forced low", {7'd0, pll_en}, 8'h00);
      wr(1'b0, 8'hFF);
      rd(1'b0, v); chk("R8 guarded bits ignore writes", v, 8'h37);
      @(negedge clk); supply_ok = 1'b1;
      wr(1'b0, 8'hC0);
      rd(1'b0, v); chk("R8 free after supply returns", v, 8'hC0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      t_reset();
      t_ctrl_rw();
      t_lock();
      t_limp();
      t_lock_irq();
      t_set_wins();
      t_nolh();
      t_supply();
      idle(2);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule